// File: doc/BRIEF.md
# Programmable Clock Divider with Synchronous Enable

This block takes a fast source clock and produces a slower clock at one of four
power-of-two ratios, selected by a two-bit code. The output is a registered
square wave with equal high and low times. In normal use the source is an
oscillator clock. In a bypass or debug setup it is a slow test clock, and the
block behaves the same way.

The ratio code normally comes from configuration latches and can change while
the divider runs. The block only adopts a new code at the boundary between two
output periods, so a period is never cut short or stretched by a change. The
active-high enable is handled the same way. Turning it off lets the running
period finish and then parks the output low. Turning it on starts a fresh, full
period. No pulse narrower than half the selected ratio can appear at the output.

Top module: `clk_ratio_div`

## Requirements
- R1: The ratio code selects the output period in source clock cycles: code 00 gives 2, code 01 gives 4, code 10 gives 8 and code 11 gives 16.
- R2: Every output period is high for exactly half the ratio in force and then low for the other half.
- R3: Reset is synchronous and active high. While reset is sampled high the output is low. With enable high, the output goes high at the first rising edge at which reset is sampled low.
- R4: Dropping the enable takes effect only at the end of the running period. Both phases of that period complete at full length, and the output then stays low.
- R5: While stopped, an enable sampled high at a rising edge starts a period at that same edge. The output is high right after that edge, for half the ratio.
- R6: A code change in the middle of a period does not alter that period. The code present at the period's last edge sets the ratio of the next period.
- R7: The output shows only whole periods: no extra, missing or partial high pulse appears across ratio changes and enable toggles.
- R8: While stopped with enable low, changes of the ratio code leave the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| out_en | input | 1 | Active-high output enable, applied at period boundaries |
| ratio_code | input | CODE_W | Ratio select: 00 /2, 01 /4, 10 /8, 11 /16 |
| div_out | output | 1 | Divided clock output, 50% duty cycle |

## Verification
A wrong count or a stale ratio register appears at the port as a high or low
phase of the wrong length, within one output period of the fault. That means at
most 16 source cycles later. The bench compares each high width and each low
width against the ratio the stimulus put in force for that period.

A wrong enable or run state appears as a shortened pulse, an extra pulse, or an
output that does not park low. These faults are caught at the first falling or
rising edge that does not match the queued pulse list. The bench also counts
the pulses seen during long stopped intervals.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Run state of the output stage.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_t;

  // Half of the output period, in source cycles, for a ratio code.
  function automatic int unsigned half_period(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Largest full ratio reachable with a code of the given width.
  function automatic int unsigned max_ratio(input int unsigned code_w);
    return 32'd2 << ((32'd1 << code_w) - 32'd1);
  endfunction

endpackage

// File: rtl/clkdiv_ratio_reg.sv
module clkdiv_ratio_reg #(
  parameter int unsigned CODE_W = 2,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  half_o
);
  import clkdiv_pkg::*;

  logic [CNT_W-1:0] half_dec;

  // Decode the code into a half-period length.
  always_comb begin
    half_dec = CNT_W'(half_period(int'(code_i)));
  end

  // Hold the half-period for the whole output period. Update only at a boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_o <= CNT_W'(1);
    end else if (load_i) begin
      half_o <= half_dec;
    end
  end

endmodule

// File: rtl/clkdiv_phase_cnt.sv
module clkdiv_phase_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W:0] last_pos;

  // Last position of a period: twice the half-period, minus one.
  always_comb begin
    last_pos = {half_i, 1'b0} - {{CNT_W{1'b0}}, 1'b1};
    wrap_o   = ({1'b0, cnt_o} == last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // The position never passes the end of the period set by the ratio register.
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_o} < {half_i, 1'b0}))
    else $error("phase count beyond period"); // R1

endmodule

// File: rtl/clkdiv_out_stage.sv
module clkdiv_out_stage #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             q_o,
  output logic             running_o
);
  import clkdiv_pkg::*;

  div_state_t       state;
  logic [CNT_W-1:0] cnt_nx;
  logic             high_nx;

  // The next position is high while it is still in the first half.
  always_comb begin
    cnt_nx  = cnt_i + CNT_W'(1);
    high_nx = (cnt_nx < half_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      q_o   <= 1'b0;
    end else if (load_i) begin
      state <= en_i ? ST_RUN : ST_IDLE;
      q_o   <= en_i;
    end else begin
      q_o   <= high_nx;
    end
  end

  assign running_o = (state == ST_RUN);

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(q_o) |-> (cnt_i == '0))
    else $error("output rose away from period start"); // R5

  AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    $fell(q_o) |-> (cnt_i == half_i))
    else $error("output fell away from half period"); // R2

  AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (rst)
    (!running_o && !en_i) |=> !q_o)
    else $error("output moved while stopped"); // R8

endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_en,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              div_out
);
  import clkdiv_pkg::*;

  localparam int unsigned MAX_RATIO = max_ratio(CODE_W);
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             running;
  logic             load;

  // A period boundary occurs at the last position of a period, or on every edge while stopped.
  assign load = wrap | ~running;

  clkdiv_ratio_reg #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) u_ratio (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .code_i (ratio_code),
    .half_o (half)
  );

  clkdiv_phase_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .half_i (half),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  clkdiv_out_stage #(
    .CNT_W (CNT_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .en_i      (out_en),
    .cnt_i     (cnt),
    .half_i    (half),
    .q_o       (div_out),
    .running_o (running)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> !div_out)
    else $error("output high after reset"); // R3

endmodule

// File: tb/tb_clk_ratio_div.sv
`timescale 1ns/1ps
module tb_clk_ratio_div;

  typedef struct {
    int    hi;
    int    lo;
    string req;
  } pulse_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       out_en = 1'b0;
  logic [1:0] ratio_code = 2'b00;
  logic       div_out;

  int n_checks = 0;
  int n_err = 0;
  int rises = 0;
  pulse_t sb[$];

  always #10 clk = ~clk;

  clk_ratio_div dut (
    .clk        (clk),
    .rst        (rst),
    .out_en     (out_en),
    .ratio_code (ratio_code),
    .div_out    (div_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int n, input int hi, input int lo, input string req);
    for (int i = 0; i < n; i++) begin
      pulse_t p;
      p.hi = hi; p.lo = lo; p.req = req;
      sb.push_back(p);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wait_rises(input int n);
    while (rises < n) step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // Monitor: measures each high and low phase at the falling clock edge
  // and compares it with the queued expectation.
  bit     prev_q = 1'b0;
  int     hi_cnt = 0;
  int     lo_cnt = 0;
  bit     low_chk = 1'b0;
  int     exp_lo = 0;
  string  lo_req = "";
  always @(negedge clk) begin
    if (rst) begin
      prev_q = 1'b0; hi_cnt = 0; lo_cnt = 0; low_chk = 1'b0;
    end else begin
      if (div_out) begin
        if (!prev_q) begin
          rises++;
          if (low_chk) check(lo_cnt == exp_lo, lo_req, lo_cnt, exp_lo);
          low_chk = 1'b0;
          hi_cnt = 0;
        end
        hi_cnt++;
      end else begin
        if (prev_q) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected pulse", hi_cnt, 0);
          end else begin
            pulse_t p;
            p = sb.pop_front();
            check(hi_cnt == p.hi, p.req, hi_cnt, p.hi);
            exp_lo  = p.lo;
            lo_req  = p.req;
            low_chk = (p.lo != 0);
          end
          lo_cnt = 0;
        end
        lo_cnt++;
      end
      prev_q = div_out;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int base;
    bit stayed_low;
    // R3: output low while reset held
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R3 reset low", int'(div_out), 0);
    step();
    // Divide by 2 start (R1, R2), enable held through reset release (R3)
    push(4, 1, 1, "R1/R2 div2");
    rst = 1'b0; out_en = 1'b1; ratio_code = 2'b00;
    @(posedge clk); @(negedge clk);
    check(div_out == 1'b1, "R3 first rise", int'(div_out), 1);
    step();
    // Switch to divide by 4 mid-period (R6)
    wait_rises(4);
    ratio_code = 2'b01;
    push(3, 2, 2, "R1/R2/R6 div4");
    // Switch to divide by 16
    wait_rises(7);
    ratio_code = 2'b11;
    push(2, 8, 8, "R1/R2/R6 div16");
    // Several code changes inside one period; only the last counts (R6)
    wait_rises(9);
    ratio_code = 2'b00;
    push(1, 4, 4, "R6 div8 after glitch");
    push(1, 4, 0, "R4 div8 last");
    repeat (3) step();
    ratio_code = 2'b10;
    // Drop enable early in a period (R4)
    wait_rises(11);
    out_en = 1'b0;
    repeat (10) step();
    check(sb.size() == 0, "R4 pending pulses", sb.size(), 0);
    base = rises;
    ratio_code = 2'b00;  // R8: code change while stopped
    stayed_low = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (div_out) stayed_low = 1'b0;
    end
    check(stayed_low && rises == base, "R8 stopped low", rises, base);
    // Re-enable: fresh full period (R5)
    push(1, 1, 1, "R5 restart");
    push(1, 1, 0, "R5 restart last");
    out_en = 1'b1;
    @(negedge clk);
    check(div_out == 1'b0, "R5 no early rise", int'(div_out), 0);
    @(posedge clk); @(negedge clk);
    check(div_out == 1'b1, "R5 rise at start", int'(div_out), 1);
    step();
    wait_rises(13);
    out_en = 1'b0;
    repeat (5) step();
    // One-cycle enable pulse still yields one full /16 period (R4, R5, R7)
    push(1, 8, 0, "R5/R7 single period");
    ratio_code = 2'b11;
    out_en = 1'b1;
    step();
    out_en = 1'b0;
    repeat (40) step();
    check(rises == 14, "R7 pulse count", rises, 14);
    check(sb.size() == 0, "R7 queue drained", sb.size(), 0);
    check(div_out == 1'b0, "R4 parked low", int'(div_out), 0);
    summary();
  end

endmodule